// File: doc/BRIEF.md
# Windowed Wide-State Readout Port

This block lets software inspect one of several wide internal state records through a single 32-bit read-only data window. A small select register names the record, and each access to the data window hands back the next 32-bit slice of that 448-bit record. An internal word pointer moves one slice forward after every access. It wraps back to the first slice once all fourteen slices have been read, so a full record is dumped in fourteen reads.

The records arrive on a flattened input bus that holds `NUM_HW_APPS + 1` populated entries: one per hardware application plus one for software. Storing and updating these records is done elsewhere. Select values past the populated entries read as zero. Data is shown only while the read-enable input is high. When it is low, the window reads as zero but still consumes the access. Writing the select register restarts the pointer at the first slice.

The pointer is held by a two-state machine. `WIN_HOME` means the pointer is on slice 0. `WIN_STEP` means a dump is part-way through.

The machine takes these transitions:
- `WIN_HOME` goes to `WIN_STEP` on a data read.
- `WIN_STEP` stays in `WIN_STEP` and advances on a data read that is not on the last slice.
- `WIN_STEP` returns to `WIN_HOME` on the read of the last slice.
- Either state returns to `WIN_HOME` on any select write.
- Either state holds when there is no access.

The data window is combinational from the current select, pointer, enable and record inputs. A read observes `rdata_o` in the cycle where `data_re_i` is high, and the pointer moves at the clock edge that ends that cycle.

Top module: `win_readout`

## Requirements
- R1: After reset the select register is 0 and the pointer is on slice 0, so with reading enabled `rdata_o` shows bits 31:0 of record 0.
- R2: Slice k of a record is bits 32k+31 down to 32k, with slice 0 at the least significant end.
- R3: Each cycle with `data_re_i` high and no select write advances the pointer by one slice. After the read of slice 13 the pointer returns to slice 0.
- R4: A select write loads `sel_wdata_i` into the select register, which is visible on `sel_o` the next cycle. The same write puts the pointer on slice 0.
- R5: When a select write and a data read fall in the same cycle, the read returns the slice for the old select and old pointer. Afterwards the pointer is on slice 0 of the new record, because the select write takes priority over the advance.
- R6: A select value of `NUM_HW_APPS + 1` or higher (up to 15) makes `rdata_o` read zero.
- R7: While `read_en_i` is low, `rdata_o` is zero, and data reads still advance the pointer.
- R8: Without a data read or a select write, the pointer holds its slice for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_we_i | input | 1 | Select register write strobe |
| sel_wdata_i | input | SEL_W (4) | Record index to write into the select register |
| sel_o | output | SEL_W (4) | Current select register value |
| data_re_i | input | 1 | Data window read strobe, one per read |
| read_en_i | input | 1 | Internal-state read enable; when low the window reads zero |
| records_i | input | (NUM_HW_APPS+1)*REC_W | Flattened records, record r at bits r*REC_W upward |
| rdata_o | output | WORD_W (32) | Data window contents |

## Verification
The bench dumps a whole record and then makes a fifteenth read. A pointer that wraps one slice early or late shows up as a wrong tagged word at that point. It interrupts a dump with a select write, including one that lands in the same cycle as a read. A design that lets the advance win, or that shows the new record during that read, returns the wrong slice. It reads while the enable is low and then raises the enable. A pointer that freezes while reading is disabled is caught, because the window shows an earlier slice than expected. Select values 3 and 15 must read zero, rather than aliasing onto a populated record.

// File: rtl/win_pkg.sv
package win_pkg;

    typedef enum logic {
        WIN_HOME = 1'b0,
        WIN_STEP = 1'b1
    } win_state_e;

endpackage

// File: rtl/win_ptr_fsm.sv
module win_ptr_fsm
    import win_pkg::*;
#(
    parameter int WORDS = 14,
    parameter int PTR_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             adv_i,
    output logic [PTR_W-1:0] ptr_o
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(WORDS - 1);

    win_state_e       state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= WIN_HOME;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            WIN_HOME: begin
                ptr_d = '0;
                if (!clr_i && adv_i && WORDS > 1) begin
                    state_d = WIN_STEP;
                    ptr_d   = PTR_W'(1);
                end
            end
            WIN_STEP: begin
                if (clr_i) begin
                    state_d = WIN_HOME;
                    ptr_d   = '0;
                end else if (adv_i) begin
                    if (ptr_q == LAST) begin
                        state_d = WIN_HOME;
                        ptr_d   = '0;
                    end else begin
                        ptr_d = ptr_q + PTR_W'(1);
                    end
                end
            end
            default: begin
                state_d = WIN_HOME;
                ptr_d   = '0;
            end
        endcase
    end

    always_comb begin
        ptr_o = (state_q == WIN_HOME) ? '0 : ptr_q;
    end

endmodule

// File: rtl/win_slice_mux.sv
module win_slice_mux #(
    parameter int NUM_REC = 3,
    parameter int REC_W   = 448,
    parameter int WORD_W  = 32,
    parameter int SEL_W   = 4,
    parameter int PTR_W   = 4
) (
    input  logic [NUM_REC*REC_W-1:0] records_i,
    input  logic [SEL_W-1:0]         sel_i,
    input  logic [PTR_W-1:0]         ptr_i,
    input  logic                     en_i,
    output logic [WORD_W-1:0]        word_o
);

    localparam int WORDS = REC_W / WORD_W;

    logic [WORD_W-1:0] slices [NUM_REC][WORDS];

    for (genvar r = 0; r < NUM_REC; r++) begin : g_rec
        for (genvar k = 0; k < WORDS; k++) begin : g_word
            assign slices[r][k] = records_i[r*REC_W + k*WORD_W +: WORD_W];
        end
    end

    always_comb begin
        word_o = '0;
        if (en_i) begin
            for (int r = 0; r < NUM_REC; r++) begin
                if (sel_i == SEL_W'(r)) begin
                    for (int k = 0; k < WORDS; k++) begin
                        if (ptr_i == PTR_W'(k)) word_o = slices[r][k];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/win_readout.sv
module win_readout #(
    parameter int NUM_HW_APPS = 2,
    parameter int REC_W       = 448,
    parameter int WORD_W      = 32,
    parameter int SEL_W       = 4,
    localparam int NUM_REC    = NUM_HW_APPS + 1,
    localparam int WORDS      = REC_W / WORD_W,
    localparam int PTR_W      = $clog2(WORDS)
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     sel_we_i,
    input  logic [SEL_W-1:0]         sel_wdata_i,
    output logic [SEL_W-1:0]         sel_o,
    input  logic                     data_re_i,
    input  logic                     read_en_i,
    input  logic [NUM_REC*REC_W-1:0] records_i,
    output logic [WORD_W-1:0]        rdata_o
);

    logic [SEL_W-1:0] sel_q;
    logic [PTR_W-1:0] ptr_w;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sel_q <= '0;
        end else if (sel_we_i) begin
            sel_q <= sel_wdata_i;
        end
    end

    assign sel_o = sel_q;

    win_ptr_fsm #(
        .WORDS (WORDS),
        .PTR_W (PTR_W)
    ) u_ptr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (sel_we_i),
        .adv_i  (data_re_i),
        .ptr_o  (ptr_w)
    );

    win_slice_mux #(
        .NUM_REC (NUM_REC),
        .REC_W   (REC_W),
        .WORD_W  (WORD_W),
        .SEL_W   (SEL_W),
        .PTR_W   (PTR_W)
    ) u_mux (
        .records_i (records_i),
        .sel_i     (sel_q),
        .ptr_i     (ptr_w),
        .en_i      (read_en_i),
        .word_o    (rdata_o)
    );

endmodule

// File: rtl/win_readout_chk.sv
module win_readout_chk #(
    parameter int NUM_REC = 3,
    parameter int WORDS   = 14,
    parameter int WORD_W  = 32,
    parameter int SEL_W   = 4,
    parameter int PTR_W   = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sel_we_i,
    input logic [SEL_W-1:0]  sel_wdata_i,
    input logic              data_re_i,
    input logic              read_en_i,
    input logic [SEL_W-1:0]  sel_o,
    input logic [WORD_W-1:0] rdata_o,
    input logic [PTR_W-1:0]  ptr_i
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(WORDS - 1);

    a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (data_re_i && !sel_we_i && ptr_i != LAST) |=> ptr_i == $past(ptr_i) + PTR_W'(1));

    a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (data_re_i && !sel_we_i && ptr_i == LAST) |=> ptr_i == '0);

    a_r3_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ptr_i <= LAST);

    a_r4_ptr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_we_i |=> ptr_i == '0);

    a_r4_sel_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_we_i |=> sel_o == $past(sel_wdata_i));

    a_r6_oor_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(sel_o) >= NUM_REC) |-> rdata_o == '0);

    a_r7_dis_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !read_en_i |-> rdata_o == '0);

    a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!data_re_i && !sel_we_i) |=> $stable(ptr_i));

endmodule

bind win_readout win_readout_chk #(
    .NUM_REC (NUM_REC),
    .WORDS   (WORDS),
    .WORD_W  (WORD_W),
    .SEL_W   (SEL_W),
    .PTR_W   (PTR_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_we_i    (sel_we_i),
    .sel_wdata_i (sel_wdata_i),
    .data_re_i   (data_re_i),
    .read_en_i   (read_en_i),
    .sel_o       (sel_o),
    .rdata_o     (rdata_o),
    .ptr_i       (ptr_w)
);

// File: tb/tb_win_readout.sv
`timescale 1ns/1ps
module tb_win_readout;

    localparam int NHW   = 2;
    localparam int NREC  = NHW + 1;
    localparam int RW    = 448;
    localparam int WW    = 32;
    localparam int NW    = RW / WW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sel_we = 1'b0;
    logic [3:0]       sel_wdata = '0;
    logic [3:0]       sel_o;
    logic             data_re = 1'b0;
    logic             read_en = 1'b1;
    logic [NREC*RW-1:0] recs;
    logic [WW-1:0]    rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    win_readout #(.NUM_HW_APPS(NHW)) dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .sel_we_i    (sel_we),
        .sel_wdata_i (sel_wdata),
        .sel_o       (sel_o),
        .data_re_i   (data_re),
        .read_en_i   (read_en),
        .records_i   (recs),
        .rdata_o     (rdata)
    );

    function automatic logic [31:0] tag_word(int r, int k);
        return {8'(r + 16), 8'(k), 16'(16'h5A00 + r * 16 + k)};
    endfunction

    task automatic check32(logic [31:0] act, logic [31:0] exp, string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_word(logic [31:0] exp, string req);
        @(negedge clk);
        data_re = 1'b1;
        #1 check32(rdata, exp, req);
        @(posedge clk);
        #1 data_re = 1'b0;
    endtask

    task automatic write_sel(logic [3:0] s);
        @(negedge clk);
        sel_we = 1'b1;
        sel_wdata = s;
        @(posedge clk);
        #1 sel_we = 1'b0;
    endtask

    task automatic peek(logic [31:0] exp, string req);
        @(negedge clk);
        #1 check32(rdata, exp, req);
    endtask

    task automatic t_reset();
        peek(tag_word(0, 0), "R1 reset word");
        check32(32'(sel_o), 32'd0, "R1 reset select");
    endtask

    task automatic t_full_dump();
        write_sel(4'd1);
        check32(32'(sel_o), 32'd1, "R4 select load");
        for (int k = 0; k < NW; k++) read_word(tag_word(1, k), "R2 R3 dump slice");
        read_word(tag_word(1, 0), "R3 wrap after 14");
        read_word(tag_word(1, 1), "R3 step after wrap");
    endtask

    task automatic t_hold();
        write_sel(4'd2);
        for (int k = 0; k < 3; k++) read_word(tag_word(2, k), "R2 rec2 slice");
        repeat (5) @(negedge clk);
        peek(tag_word(2, 3), "R8 hold idle");
        read_word(tag_word(2, 3), "R8 resume");
    endtask

    task automatic t_select_reset();
        write_sel(4'd0);
        peek(tag_word(0, 0), "R4 pointer cleared");
        check32(32'(sel_o), 32'd0, "R4 select readback");
    endtask

    task automatic t_same_cycle();
        write_sel(4'd0);
        read_word(tag_word(0, 0), "R5 pre");
        read_word(tag_word(0, 1), "R5 pre");
        @(negedge clk);
        data_re = 1'b1;
        sel_we = 1'b1;
        sel_wdata = 4'd2;
        #1 check32(rdata, tag_word(0, 2), "R5 old data in collision");
        @(posedge clk);
        #1 begin data_re = 1'b0; sel_we = 1'b0; end
        peek(tag_word(2, 0), "R5 select wins");
    endtask

    task automatic t_out_of_range();
        write_sel(4'd3);
        read_word(32'd0, "R6 select 3 zero");
        read_word(32'd0, "R6 select 3 zero");
        write_sel(4'd15);
        read_word(32'd0, "R6 select 15 zero");
        check32(32'(sel_o), 32'd15, "R4 select 15 readback");
    endtask

    task automatic t_disabled();
        write_sel(4'd1);
        read_en = 1'b0;
        for (int k = 0; k < 4; k++) read_word(32'd0, "R7 disabled zero");
        read_en = 1'b1;
        peek(tag_word(1, 4), "R7 pointer advanced while disabled");
        read_word(tag_word(1, 4), "R7 enabled again");
    endtask

    initial begin
        for (int r = 0; r < NREC; r++)
            for (int k = 0; k < NW; k++)
                recs[r*RW + k*WW +: WW] = tag_word(r, k);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_dump();
        t_hold();
        t_select_reset();
        t_same_cycle();
        t_out_of_range();
        t_disabled();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule